// File: doc/BRIEF.md
# Protected Processor Status Word

This block keeps the 32-bit status word of a processor core and presents each of its fields to the rest of the core: the current execution priority, the device-interrupt enable, the four arithmetic condition flags, six privilege flags, the 6-bit memory page selector and ten bits of general-purpose storage. The whole word is always visible on a read port, and each field also has its own output.

Two paths change the word. Software writes arrive on a write port and are filtered: the condition flags and two reserved bits never take written data, and the page selector takes written data only while the memory-manager privilege flag (bit 15) is already set. An unprivileged write that asks for a different page leaves the page alone and raises a violation pulse for one cycle. The arithmetic unit owns the condition flags through a separate update port. Both paths may act in the same cycle, each on its own fields.

The block also decides whether a requesting device may interrupt. A request is accepted when interrupts are enabled and the requesting level is strictly above the current priority. Device levels normally lie in 4 to 7, software levels in 1 to 3, and ordinary code runs at priority 0.

Top module: `status_word_reg`

## Requirements
- R1: A synchronous active-high reset clears all 32 bits of the word and the violation output to 0.
- R2: A software write stores its data into bits 31–22 (free storage), bits 15–10 (privilege flags), bit 3 (interrupt enable) and bits 2–0 (priority); the new word is visible on the read port in the cycle after the write.
- R3: Bits 5–4 are reserved and always read as 0, whatever value a write carries.
- R4: A software write never changes bits 9–6 (condition flags).
- R5: A flag update loads its 4-bit input into bits 9–6 with input bit 3 into bit 9 (overflow), bit 2 into bit 8 (carry), bit 1 into bit 7 (zero) and bit 0 into bit 6 (negative), leaving all other bits unchanged.
- R6: A software write changes bits 21–16 (page) only when bit 15 of the word held before the write is 1; otherwise the page keeps its old value.
- R7: The violation output is 1 for the one cycle after an unprivileged software write whose page field differs from the current page, and 0 after any other cycle.
- R8: When a software write and a flag update happen in the same cycle, both are applied: the flags come from the update and the writable fields from the write.
- R9: The interrupt-accept output is combinationally 1 exactly when the request is valid, bit 3 is 1 and the 3-bit requesting level is strictly greater than bits 2–0.
- R10: The field outputs equal the corresponding slices of the read port: priority bits 2–0, enable bit 3, flags bits 9–6, privilege bits 15–10, page bits 21–16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write data |
| flag_upd_en | input | 1 | Flag update strobe from the arithmetic unit |
| flag_upd_vczn | input | 4 | New flags: overflow, carry, zero, negative (bit 3 down to 0) |
| dev_req_valid | input | 1 | A device is requesting an interrupt |
| dev_req_level | input | 3 | Priority level of the requesting device |
| status_out | output | 32 | Full status word (read port) |
| prio_out | output | 3 | Current priority |
| irq_en_out | output | 1 | Device-interrupt enable |
| flags_out | output | 4 | Condition flags, overflow to negative |
| priv_out | output | 6 | Privilege flags |
| page_out | output | 6 | Memory page selector |
| irq_accept | output | 1 | Device request accepted |
| priv_violation | output | 1 | One-cycle pulse after a refused page change |

## Verification
The two functions that can collide are a software write and a flag update landing on the same clock edge, and the same edge can also carry a refused page change. The bench provokes this by raising both strobes in one cycle with write data that sets every flag and reserved bit and asks for a new page without privilege. It judges the result by checking that the read port holds the written free, privilege, enable and priority bits, the updated flags, the old page and zero reserved bits, and that the violation pulse appears in that same next cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int WORD_W   = 32;
    localparam int PRIO_W   = 3;
    localparam int RSVD_W   = 2;
    localparam int FLAG_W   = 4;
    localparam int PRIV_W   = 6;
    localparam int PAGE_W   = 6;
    localparam int FREE_W   = WORD_W - PRIO_W - 1 - RSVD_W - FLAG_W - PRIV_W - PAGE_W;

    // bit positions derived from widths (low to high)
    localparam int PRIO_LO  = 0;
    localparam int IE_BIT   = PRIO_LO + PRIO_W;
    localparam int RSVD_LO  = IE_BIT + 1;
    localparam int FLAG_LO  = RSVD_LO + RSVD_W;
    localparam int PRIV_LO  = FLAG_LO + FLAG_W;
    localparam int PAGE_LO  = PRIV_LO + PRIV_W;
    localparam int FREE_LO  = PAGE_LO + PAGE_W;

    // privilege flag index (within the privilege field) that guards the page
    localparam int MGR_IDX  = PRIV_W - 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [FREE_W-1:0] spare;
        logic [PAGE_W-1:0] page;
        logic [PRIV_W-1:0] priv;
        logic [FLAG_W-1:0] vczn;
        logic [RSVD_W-1:0] rsvd;
        logic              ie;
        logic [PRIO_W-1:0] prio;
    } psw_t;

    function automatic word_t span_mask(input int lo, input int width);
        word_t m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i >= lo && i < lo + width) m[i] = 1'b1;
        end
        return m;
    endfunction

    // fields that any software write may load
    function automatic word_t open_mask();
        return span_mask(FREE_LO, FREE_W) | span_mask(PRIV_LO, PRIV_W)
             | span_mask(IE_BIT, 1) | span_mask(PRIO_LO, PRIO_W);
    endfunction

    function automatic word_t page_mask();
        return span_mask(PAGE_LO, PAGE_W);
    endfunction

    function automatic word_t rsvd_mask();
        return span_mask(RSVD_LO, RSVD_W);
    endfunction

endpackage

// File: rtl/psw_sw_merge.sv
module psw_sw_merge
    import psw_pkg::*;
(
    input  psw_t  cur,
    input  logic  wr_en,
    input  word_t wr_data,
    output psw_t  nxt,
    output logic  page_refused
);
    logic  has_mgr;
    word_t take;
    word_t wr_view;
    word_t cur_view;

    assign has_mgr  = cur.priv[MGR_IDX];
    assign take     = open_mask() | (has_mgr ? page_mask() : '0);
    assign cur_view = word_t'(cur);
    assign wr_view  = wr_data;

    always_comb begin
        if (wr_en) begin
            nxt = psw_t'(((wr_view & take) | (cur_view & ~take)) & ~rsvd_mask());
        end else begin
            nxt = psw_t'(cur_view & ~rsvd_mask());
        end
    end

    assign page_refused = wr_en && !has_mgr
                       && (wr_data[PAGE_LO +: PAGE_W] != cur.page);

endmodule

// File: rtl/psw_flag_merge.sv
module psw_flag_merge
    import psw_pkg::*;
(
    input  psw_t              base,
    input  logic              upd_en,
    input  logic [FLAG_W-1:0] upd_vczn,
    output psw_t              merged
);
    always_comb begin
        merged = base;
        if (upd_en) merged.vczn = upd_vczn;
    end
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate
    import psw_pkg::*;
(
    input  logic              ie,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic              req_valid,
    input  logic [PRIO_W-1:0] req_level,
    output logic              accept
);
    logic above;
    assign above  = req_level > cur_prio;
    assign accept = req_valid & ie & above;
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
    import psw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_wr_en,
    input  logic [WORD_W-1:0]   sw_wr_data,
    input  logic                flag_upd_en,
    input  logic [FLAG_W-1:0]   flag_upd_vczn,
    input  logic                dev_req_valid,
    input  logic [PRIO_W-1:0]   dev_req_level,
    output logic [WORD_W-1:0]   status_out,
    output logic [PRIO_W-1:0]   prio_out,
    output logic                irq_en_out,
    output logic [FLAG_W-1:0]   flags_out,
    output logic [PRIV_W-1:0]   priv_out,
    output logic [PAGE_W-1:0]   page_out,
    output logic                irq_accept,
    output logic                priv_violation
);
    psw_t cur_q;
    psw_t after_sw;
    psw_t after_all;
    logic refused;

    psw_sw_merge u_sw (
        .cur          (cur_q),
        .wr_en        (sw_wr_en),
        .wr_data      (sw_wr_data),
        .nxt          (after_sw),
        .page_refused (refused)
    );

    psw_flag_merge u_flag (
        .base     (after_sw),
        .upd_en   (flag_upd_en),
        .upd_vczn (flag_upd_vczn),
        .merged   (after_all)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q          <= '0;
            priv_violation <= 1'b0;
        end else begin
            cur_q          <= after_all;
            priv_violation <= refused;
        end
    end

    psw_irq_gate u_irq (
        .ie        (cur_q.ie),
        .cur_prio  (cur_q.prio),
        .req_valid (dev_req_valid),
        .req_level (dev_req_level),
        .accept    (irq_accept)
    );

    assign status_out = word_t'(cur_q);
    assign prio_out   = cur_q.prio;
    assign irq_en_out = cur_q.ie;
    assign flags_out  = cur_q.vczn;
    assign priv_out   = cur_q.priv;
    assign page_out   = cur_q.page;

    // R3: reserved bits stay zero in the stored word
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
        status_out[RSVD_LO +: RSVD_W] == '0);

    // R4: without a flag update the flags do not move
    p_flags_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !flag_upd_en |=> $stable(flags_out));

    // R6: no page change while the manager privilege is clear
    p_page_guard_r6: assert property (@(posedge clk) disable iff (rst)
        !priv_out[MGR_IDX] |=> $stable(page_out));

    // R7: a violation pulse always follows a software write
    p_violation_cause_r7: assert property (@(posedge clk) disable iff (rst)
        priv_violation |-> $past(sw_wr_en));

    // R9: acceptance needs a valid request and the enable bit
    p_accept_gate_r9: assert property (@(posedge clk) disable iff (rst)
        irq_accept |-> (dev_req_valid && irq_en_out));

endmodule

// File: tb/status_word_reg_test.sv
module status_word_reg_test;
    import psw_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        sw_wr_en;
    logic [31:0] sw_wr_data;
    logic        flag_upd_en;
    logic [3:0]  flag_upd_vczn;
    logic        dev_req_valid;
    logic [2:0]  dev_req_level;
    logic [31:0] status_out;
    logic [2:0]  prio_out;
    logic        irq_en_out;
    logic [3:0]  flags_out;
    logic [5:0]  priv_out;
    logic [5:0]  page_out;
    logic        irq_accept;
    logic        priv_violation;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_word = '0;
    logic        exp_viol = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    status_word_reg uut (
        .clk(clk), .rst(rst),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .flag_upd_en(flag_upd_en), .flag_upd_vczn(flag_upd_vczn),
        .dev_req_valid(dev_req_valid), .dev_req_level(dev_req_level),
        .status_out(status_out), .prio_out(prio_out), .irq_en_out(irq_en_out),
        .flags_out(flags_out), .priv_out(priv_out), .page_out(page_out),
        .irq_accept(irq_accept), .priv_violation(priv_violation)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock with both strobes; expected word built from the requirements
    task automatic step(input logic we, input logic [31:0] d, input logic fe, input logic [3:0] f);
        logic [31:0] nxt;
        logic        priv;
        priv = exp_word[15];
        nxt  = exp_word;
        exp_viol = 1'b0;
        if (we) begin
            nxt = d & 32'hFFC0_FC0F;             // R2 fields, R3/R4 masked
            nxt[9:6] = exp_word[9:6];
            if (!priv) begin
                nxt[21:16] = exp_word[21:16];    // R6
                exp_viol = (d[21:16] != exp_word[21:16]);
            end
        end
        if (fe) nxt[9:6] = f;                    // R5
        exp_word = nxt;
        @(negedge clk);
        sw_wr_en = we; sw_wr_data = d; flag_upd_en = fe; flag_upd_vczn = f;
        @(negedge clk);
        sw_wr_en = 1'b0; flag_upd_en = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 word after reset", status_out, 32'h0);
        check("R1 violation after reset", {31'b0, priv_violation}, 32'h0);
    endtask

    task automatic t_unpriv_all_ones;
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 4'h0);
        check("R2 open fields written", status_out, 32'hFFC0_FC0F);
        check("R2 model agrees", status_out, exp_word);
        check("R3 reserved read zero", {30'b0, status_out[5:4]}, 32'h0);
        check("R4 flags unchanged by write", {28'b0, flags_out}, 32'h0);
        check("R6 page held without privilege", {26'b0, page_out}, 32'h0);
        check("R7 violation pulse", {31'b0, priv_violation}, 32'h1);
        @(negedge clk);
        check("R7 violation drops", {31'b0, priv_violation}, 32'h0);
    endtask

    task automatic t_priv_page;
        step(1'b1, 32'h0017_8000, 1'b0, 4'h0);
        check("R6 privileged page change", status_out, 32'h0017_8000);
        check("R7 no violation when privileged", {31'b0, priv_violation}, 32'h0);
        check("R10 page field", {26'b0, page_out}, 32'h17);
        check("R10 privilege field", {26'b0, priv_out}, 32'h20);
    endtask

    task automatic t_flag_update;
        step(1'b0, 32'h0, 1'b1, 4'b1010);
        check("R5 overflow and zero set", status_out, 32'h0017_8280);
        check("R10 flags field", {28'b0, flags_out}, 32'hA);
    endtask

    task automatic t_write_keeps_flags;
        step(1'b1, 32'h0000_03FA, 1'b0, 4'h0);
        check("R4 write of flag bits ignored", status_out, 32'h0000_028A);
        check("R10 priority and enable", {28'b0, irq_en_out, prio_out}, 32'hA);
        step(1'b1, 32'h0000_0005, 1'b0, 4'h0);
        check("R7 same page no violation", {31'b0, priv_violation}, 32'h0);
        check("R2 unprivileged write same page", status_out, 32'h0000_0285);
    endtask

    task automatic t_simultaneous;
        step(1'b1, 32'h5550_1FFB, 1'b1, 4'b0101);
        check("R8 both applied", status_out, 32'h5540_1D4B);
        check("R8 model agrees", status_out, exp_word);
        check("R8 violation in same cycle", {31'b0, priv_violation}, {31'b0, exp_viol});
    endtask

    task automatic t_irq;
        // priority 3, enable 1 from the previous write
        dev_req_valid = 1'b1; dev_req_level = 3'd3; #1;
        check("R9 equal level refused", {31'b0, irq_accept}, 32'h0);
        dev_req_level = 3'd4; #1;
        check("R9 higher level accepted", {31'b0, irq_accept}, 32'h1);
        dev_req_valid = 1'b0; #1;
        check("R9 no request", {31'b0, irq_accept}, 32'h0);
        step(1'b1, 32'h0000_0000, 1'b0, 4'h0);
        dev_req_valid = 1'b1; dev_req_level = 3'd7; #1;
        check("R9 disabled blocks", {31'b0, irq_accept}, 32'h0);
        step(1'b1, 32'h0000_0008, 1'b0, 4'h0);
        dev_req_level = 3'd1; #1;
        check("R9 level 1 over priority 0", {31'b0, irq_accept}, 32'h1);
        step(1'b1, 32'h0000_000F, 1'b0, 4'h0);
        dev_req_level = 3'd7; #1;
        check("R9 level 7 at priority 7 refused", {31'b0, irq_accept}, 32'h0);
        dev_req_valid = 1'b0;
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_word = '0;
        check("R1 reset clears populated word", status_out, 32'h0);
    endtask

    initial begin
        rst = 1'b1; sw_wr_en = 1'b0; sw_wr_data = '0;
        flag_upd_en = 1'b0; flag_upd_vczn = '0;
        dev_req_valid = 1'b0; dev_req_level = '0;
        t_reset;
        t_unpriv_all_ones;
        t_priv_page;
        t_flag_update;
        t_write_keeps_flags;
        t_simultaneous;
        t_irq;
        t_reset_again;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule